// File: doc/BRIEF.md
# SPI Slave Byte Engine with Busy Handshake

This block is an SPI slave that works entirely in the fast system clock domain. The serial clock, the chip select and the master-out data line each pass through a synchronizer. Edges are then found on the synchronized serial clock. The block moves data in units of `BITS` bits, most significant bit first. Each received unit is handed to the internal logic as a parallel word with a one-cycle strobe. The next word to send is taken back from the internal logic through a load strobe.

The block has three states:

- `ST_WAIT_IDLE` is entered at reset. The block leaves it for `ST_READY` once the synchronizer has filled and the synchronized serial clock sits at the configured idle level.
- `ST_READY` is the only state in which bits are shifted. When the last sample edge of a unit arrives, the block moves to `ST_PROCESS`.
- `ST_PROCESS` returns to `ST_READY` when the internal logic asserts `tx_load`.

The `busy` output is high in every state except `ST_READY`. The master must wait for it to fall before it starts the next unit. Deselecting the slave puts the output driver into high impedance and drops any partial unit. It does not move the block out of `ST_PROCESS`. Clock polarity and phase are static configuration inputs. They may change only while reset is held.

Top module: `spi_byte_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy` is 1, `rx_valid` is 0 and `miso_oe` is 0.
- R2: After reset the block stays in `ST_WAIT_IDLE` with `busy` high while the serial clock pin differs from `cfg_cpol`. Once the pin reaches `cfg_cpol`, `busy` falls on the third rising system-clock edge.
- R3: A leading edge is a serial clock transition away from the idle level `cfg_cpol`. With `cfg_cpha`=0 the slave samples on leading edges and shifts on trailing edges. With `cfg_cpha`=1 it shifts on leading edges, except the first of a unit, and samples on trailing edges. Data is MSB first in both directions, and all four polarity/phase combinations work.
- R4: The block responds to the `BITS`-th sample edge on the third system-clock edge after that serial clock pin change. On that edge `rx_data` holds the unit, `rx_valid` is 1, `busy` rises and the state becomes `ST_PROCESS`.
- R5: In `ST_PROCESS`, serial clock edges are ignored and `busy` stays high. A `tx_load` pulse sends the block to `ST_READY`: `busy` is 0 one edge later, and `tx_data` becomes the next unit shifted out.
- R6: `tx_load` is accepted in `ST_WAIT_IDLE` and `ST_PROCESS`. In `ST_READY` it is ignored: `busy` stays low and the word being sent is unchanged.
- R7: `miso_oe` is the inverse of the chip select pin delayed by the synchronizer depth, which is two system-clock edges by default.
- R8: Serial clock edges while chip select is high are ignored. Chip select going high partway through a unit discards the received bits, clears the bit count and restores the whole word being sent.
- R9: Chip select going high in `ST_PROCESS` does not end processing: `busy` stays high until `tx_load`.
- R10: `rx_valid` is exactly one cycle wide, and there is one pulse per complete unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for `miso_o` (high impedance when 0) |
| busy | output | 1 | Handshake: master must not start a unit while high |
| rx_data | output | BITS | Last received unit |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_load | input | 1 | Processing done; loads `tx_data` |
| tx_data | input | BITS | Next unit to transmit |

## Verification
Each result has a fixed delay after its stimulus:

- `rx_valid`, `rx_data` and the rise of `busy` appear three system-clock edges after the pin change of the final sample edge.
- The fall of `busy` at the end of `ST_WAIT_IDLE` also comes three edges after the serial clock pin reaches its idle level.
- `miso_oe` follows chip select after two edges.
- `busy` falls one edge after `tx_load`.

The bench drives every pin just after a falling clock edge and counts falling edges from that point. It checks the value in the cycle before each result is due and again in the cycle it is due, so a result that comes early or late is reported. The serial clock half period is eight system cycles, so transmit bits have settled well before the master model samples them.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_IDLE = 2'd0,
        ST_READY     = 2'd1,
        ST_PROCESS   = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spi_eng_sync.sv
module spi_eng_sync #(
    parameter int             WIDTH   = 3,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q,
    output logic             vld
);

    logic [WIDTH-1:0]  stg [STAGES];
    logic [STAGES-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= RST_VAL;
        end else begin
            stg[0] <= d;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[s] <= RST_VAL;
            end else begin
                stg[s] <= stg[s-1];
            end
        end
    end

    // Marks when every stage holds a sampled pin value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill <= '0;
        end else begin
            fill <= {fill[STAGES-2:0], 1'b1};
        end
    end

    assign q   = stg[STAGES-1];
    assign vld = fill[STAGES-1];

endmodule

// File: rtl/spi_eng_edge.sv
module spi_eng_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cpol,
    input  logic cpha,
    output logic sample_ev,
    output logic shift_ev
);

    logic sclk_d;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    always_comb begin
        rise      = sclk_s & ~sclk_d;
        fall      = ~sclk_s & sclk_d;
        lead      = cpol ? fall : rise;
        trail     = cpol ? rise : fall;
        sample_ev = cpha ? trail : lead;
        shift_ev  = cpha ? lead : trail;
    end

endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cs_hi,
    input  logic            cpha,
    input  logic            sample_ev,
    input  logic            shift_ev,
    input  logic            mosi_s,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    output logic            miso_bit,
    output logic            unit_done,
    output logic [BITS-1:0] rx_data,
    output logic            rx_valid
);

    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic [CW-1:0]   cnt;
    logic [BITS-2:0] rx_sh;
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] tx_hold;
    logic            active;

    assign active    = en && !cs_hi;
    assign unit_done = active && sample_ev && (cnt == LAST);
    assign miso_bit  = tx_sh[BITS-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            tx_hold  <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (load) begin
                tx_hold <= load_data;
                tx_sh   <= load_data;
                cnt     <= '0;
            end else if (cs_hi) begin
                cnt   <= '0;
                tx_sh <= tx_hold;
            end else if (en) begin
                if (sample_ev) begin
                    rx_sh <= {rx_sh[BITS-3:0], mosi_s};
                    if (cnt == LAST) begin
                        cnt      <= '0;
                        rx_data  <= {rx_sh, mosi_s};
                        rx_valid <= 1'b1;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                if (shift_ev && !(cpha && cnt == '0)) begin
                    tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
    import spi_eng_pkg::*;
#(
    parameter int BITS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            sclk,
    input  logic            cs_n,
    input  logic            mosi,
    output logic            miso_o,
    output logic            miso_oe,
    output logic            busy,
    output logic [BITS-1:0] rx_data,
    output logic            rx_valid,
    input  logic            tx_load,
    input  logic [BITS-1:0] tx_data
);

    eng_state_t state, state_nx;
    logic [2:0] pins_s;
    logic       sync_vld;
    logic       sclk_s, cs_s, mosi_s;
    logic       sample_ev, shift_ev;
    logic       unit_done, load_ok, shift_en, miso_bit;

    // Order {sclk, cs_n, mosi}; chip select resets to deselected.
    spi_eng_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, cs_n, mosi}),
        .q    (pins_s),
        .vld  (sync_vld)
    );

    assign sclk_s = pins_s[2];
    assign cs_s   = pins_s[1];
    assign mosi_s = pins_s[0];

    spi_eng_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .sample_ev(sample_ev),
        .shift_ev (shift_ev)
    );

    spi_eng_shift #(
        .BITS(BITS)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (shift_en),
        .cs_hi    (cs_s),
        .cpha     (cfg_cpha),
        .sample_ev(sample_ev),
        .shift_ev (shift_ev),
        .mosi_s   (mosi_s),
        .load     (load_ok),
        .load_data(tx_data),
        .miso_bit (miso_bit),
        .unit_done(unit_done),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT_IDLE: if (sync_vld && (sclk_s == cfg_cpol)) state_nx = ST_READY;
            ST_READY:     if (unit_done) state_nx = ST_PROCESS;
            ST_PROCESS:   if (tx_load) state_nx = ST_READY;
            default:      state_nx = ST_WAIT_IDLE;
        endcase
    end

    always_comb begin
        busy     = (state != ST_READY);
        shift_en = (state == ST_READY);
        load_ok  = tx_load && (state != ST_READY);
        miso_oe  = ~cs_s;
        miso_o   = miso_bit;
    end

endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso_oe,
    input logic busy,
    input logic rx_valid,
    input logic tx_load
);

    logic [SYNC_STAGES-1:0] cs_hist;
    logic [SYNC_STAGES-1:0] settled;
    logic                   seen_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_hist    <= '1;
            settled    <= '0;
            seen_ready <= 1'b0;
        end else begin
            cs_hist    <= {cs_hist[SYNC_STAGES-2:0], cs_n};
            settled    <= {settled[SYNC_STAGES-2:0], 1'b1};
            if (!busy) seen_ready <= 1'b1;
        end
    end

    // R4: a received unit is always accompanied by busy
    a_r4_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);

    // R4: busy only rises when a unit completes
    a_r4_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> rx_valid);

    // R5: after startup, busy only falls following tx_load
    a_r5_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && seen_ready) |-> $past(tx_load));

    // R10: strobe is a single cycle
    a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: output enable tracks delayed chip select
    a_r7_oe_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
        settled[SYNC_STAGES-1] |-> (miso_oe == !cs_hist[SYNC_STAGES-1]));

endmodule

bind spi_byte_engine spi_byte_engine_chk #(
    .SYNC_STAGES(SYNC_STAGES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .miso_oe (miso_oe),
    .busy    (busy),
    .rx_valid(rx_valid),
    .tx_load (tx_load)
);

// File: tb/spi_byte_engine_tb.sv
`timescale 1ns/1ps
module spi_byte_engine_tb;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       miso_o, miso_oe, busy, rx_valid;
    logic [7:0] rx_data;

    int   n_chk = 0, n_fail = 0, rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    spi_byte_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso_o(miso_o),
        .miso_oe(miso_oe), .busy(busy), .rx_data(rx_data),
        .rx_valid(rx_valid), .tx_load(tx_load), .tx_data(tx_data)
    );

    always @(posedge clk) begin
        #1;
        if (rx_valid) begin
            rx_cnt++;
            rx_last = rx_data;
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (act=timeout exp=done)");
        report();
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic pol, input logic pha, input logic sclk_lvl);
        @(negedge clk);
        rst_n = 1'b0; cfg_cpol = pol; cfg_cpha = pha; sclk = sclk_lvl;
        cs_n = 1'b1; mosi = 1'b0; tx_load = 1'b0;
        nclk(4);
        rst_n = 1'b1;
    endtask

    task automatic load_tx(input logic [7:0] b);
        tx_load = 1'b1; tx_data = b;
        nclk(1);
        tx_load = 1'b0;
    endtask

    // Master model: shifts nbits MSB first; optional timing checks on the final sample edge.
    task automatic spi_bits(input logic [7:0] mo, input int nbits, input bit timed,
                            output logic [7:0] mi);
        mi = 8'h00;
        cs_n = 1'b0;
        nclk(4);
        for (int i = 0; i < nbits; i++) begin
            if (!cfg_cpha) begin
                mosi = mo[7-i];
                nclk(HALF);
                mi = {mi[6:0], miso_o};
                sclk = ~cfg_cpol;
            end else begin
                sclk = ~cfg_cpol;
                mosi = mo[7-i];
                nclk(HALF);
                mi = {mi[6:0], miso_o};
                sclk = cfg_cpol;
            end
            if (timed && i == nbits - 1) begin
                nclk(2);
                check(busy == 1'b0, "R4", "busy early", busy, 0);
                check(rx_valid == 1'b0, "R4", "rx_valid early", rx_valid, 0);
                nclk(1);
                check(busy == 1'b1, "R4", "busy on third edge", busy, 1);
                check(rx_valid == 1'b1, "R4", "rx_valid on third edge", rx_valid, 1);
                check(rx_data == mo, "R4", "rx_data", rx_data, mo);
                nclk(1);
                check(rx_valid == 1'b0, "R10", "rx_valid width", rx_valid, 0);
                nclk(HALF - 4);
            end else begin
                nclk(HALF);
            end
            if (!cfg_cpha) sclk = cfg_cpol;
        end
        nclk(HALF);
    endtask

    task automatic xfer_check(input logic [7:0] mo, input logic [7:0] exp_mi, input string req);
        int c0;
        c0 = rx_cnt;
        spi_bits(mo, 8, 1'b0, got);
        check(rx_cnt == c0 + 1, req, "one strobe per unit", rx_cnt - c0, 1);
        check(rx_last == mo, req, "received unit", rx_last, mo);
        check(got == exp_mi, req, "transmitted unit", got, exp_mi);
        check(busy == 1'b1, req, "busy after unit", busy, 1);
    endtask

    task automatic t_reset_state();
        do_reset(1'b0, 1'b0, 1'b0);
        check(busy == 1'b1, "R1", "busy in reset", busy, 1);
        check(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        check(miso_oe == 1'b0, "R1", "miso_oe in reset", miso_oe, 0);
        nclk(1);
        check(busy == 1'b1, "R1", "busy after release", busy, 1);
        check(miso_oe == 1'b0, "R1", "miso_oe after release", miso_oe, 0);
    endtask

    task automatic t_startup_stall();
        do_reset(1'b1, 1'b1, 1'b0);
        nclk(30);
        check(busy == 1'b1, "R2", "blocked with sclk off idle", busy, 1);
        load_tx(8'hA5);
        check(busy == 1'b1, "R6", "load in wait keeps busy", busy, 1);
        sclk = 1'b1;
        nclk(2);
        check(busy == 1'b1, "R2", "busy before idle seen", busy, 1);
        nclk(1);
        check(busy == 1'b0, "R2", "busy falls on third edge", busy, 0);
        xfer_check(8'h3C, 8'hA5, "R3");
        load_tx(8'h5A);
        check(busy == 1'b0, "R5", "busy one edge after load", busy, 0);
        xfer_check(8'hC3, 8'h5A, "R3");
        load_tx(8'h00);
    endtask

    task automatic t_mode(input logic pol, input logic pha);
        do_reset(pol, pha, pol);
        nclk(6);
        check(busy == 1'b0, "R2", "ready when idle at reset", busy, 0);
        @(negedge clk);
        rst_n = 1'b0;
        nclk(1);
        rst_n = 1'b1;
        load_tx(8'hB4);
        nclk(6);
        xfer_check(8'h6D, 8'hB4, "R3");
        load_tx(8'h11);
        xfer_check(8'h92, 8'h11, "R3");
        load_tx(8'h00);
    endtask

    task automatic t_timing_and_oe();
        do_reset(1'b0, 1'b0, 1'b0);
        load_tx(8'hE7);
        nclk(6);
        spi_bits(8'h29, 8, 1'b1, got);
        check(got == 8'hE7, "R3", "mode0 transmit", got, 8'hE7);
        cs_n = 1'b1;
        nclk(1);
        check(miso_oe == 1'b1, "R7", "oe held one edge", miso_oe, 1);
        nclk(1);
        check(miso_oe == 1'b0, "R7", "oe off after two edges", miso_oe, 0);
        nclk(5);
        check(busy == 1'b1, "R9", "deselect keeps processing", busy, 1);
        cs_n = 1'b0;
        nclk(1);
        check(miso_oe == 1'b0, "R7", "oe still off", miso_oe, 0);
        nclk(1);
        check(miso_oe == 1'b1, "R7", "oe on after two edges", miso_oe, 1);
        load_tx(8'hC8);
        check(busy == 1'b0, "R5", "load ends processing", busy, 0);
    endtask

    task automatic t_ready_ignore();
        load_tx(8'hFF);
        nclk(2);
        check(busy == 1'b0, "R6", "load in ready keeps busy low", busy, 0);
        xfer_check(8'h55, 8'hC8, "R6");
    endtask

    task automatic t_process_ignore();
        int c0;
        c0 = rx_cnt;
        for (int k = 0; k < 16; k++) begin
            sclk = ~sclk;
            mosi = k[0];
            nclk(HALF);
        end
        check(rx_cnt == c0, "R5", "edges ignored while processing", rx_cnt - c0, 0);
        check(busy == 1'b1, "R5", "busy held while processing", busy, 1);
        load_tx(8'h3A);
        xfer_check(8'hA3, 8'h3A, "R5");
    endtask

    task automatic t_abort();
        int c0;
        load_tx(8'h96);
        c0 = rx_cnt;
        spi_bits(8'hE0, 3, 1'b0, got);
        cs_n = 1'b1;
        nclk(6);
        check(rx_cnt == c0, "R8", "partial unit discarded", rx_cnt - c0, 0);
        xfer_check(8'h81, 8'h96, "R8");
        load_tx(8'h4E);
        cs_n = 1'b1;
        nclk(4);
        c0 = rx_cnt;
        for (int k = 0; k < 6; k++) begin
            sclk = ~sclk;
            nclk(HALF);
        end
        check(rx_cnt == c0, "R8", "edges ignored while deselected", rx_cnt - c0, 0);
        xfer_check(8'h18, 8'h4E, "R8");
    endtask

    initial begin
        t_reset_state();
        t_startup_stall();
        t_mode(1'b0, 1'b0);
        t_mode(1'b0, 1'b1);
        t_mode(1'b1, 1'b0);
        t_timing_and_oe();
        t_ready_ignore();
        t_process_ignore();
        t_abort();
        nclk(4);
        report();
    end

endmodule